// File: doc/BRIEF.md
# Periodic Tick Interrupt Timer

This block times a fixed interval measured in clock cycles and, when the interval has run out, raises a level interrupt request toward the processor. The request is sticky: it stays asserted until the processor returns a single-cycle acknowledge. The acknowledge clears the request and starts the next interval, so the timer is never free-running. The spacing between ticks is therefore one full interval plus however long the processor takes to respond.

The interval length is the parameter `PERIOD`. Its default corresponds to 10 ms at a 100 MHz clock. A bench may set a much smaller value. While the request is pending the internal count is frozen, and no new interval begins until the acknowledge arrives. A synchronous reset behaves like an acknowledge. It also forces the request low.

Top module: `tick_timer`

## Requirements
- R1: While `rst` is sampled high, and during the first `PERIOD`-1 clock edges after the last edge at which `rst` was sampled high, `irq` is 0.
- R2: Counting the edges after the last edge at which `rst` or `ack` was sampled high, `irq` becomes 1 on exactly edge number `PERIOD` when no `ack` arrives in between.
- R3: Once `irq` is 1 it stays 1 on every following edge at which neither `ack` nor `rst` is sampled high.
- R4: An edge at which `ack` is sampled high leaves `irq` at 0 after that edge.
- R5: After an acknowledge that clears a pending `irq`, the next rise of `irq` comes exactly `PERIOD` edges after the acknowledging edge. No time spent while `irq` was high is credited to the new interval.
- R6: An `ack` sampled while `irq` is 0 keeps `irq` at 0 and restarts the interval, so the rise moves to `PERIOD` edges after that `ack`.
- R7: An `ack` sampled on the very edge at which the interval would expire takes priority: `irq` stays 0, and a new full interval starts.
- R8: Holding `ack` high for many cycles keeps `irq` at 0 throughout. The interval is then timed from the last edge at which `ack` was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the request and the count |
| ack | input | 1 | Acknowledge from the processor; clears the request and restarts the interval |
| irq | output | 1 | Level interrupt request, sticky until acknowledged |

## Verification
The checker keeps its own count of edges since the last clearing event. On every cycle it checks that the request equals "count reached `PERIOD`", which covers exact rise timing, stickiness, acknowledge clearing and the priority of the acknowledge over expiry. Behaviours that need a chosen order of events can only be shown by the bench's scenarios. These include an acknowledge landing exactly on the expiry edge, an acknowledge arriving mid-interval, and a long held acknowledge. The bench also mixes in randomly spaced acknowledges, against a model of the elapsed count.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int unsigned PERIOD = 1_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  output logic irq
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt;
  logic          last;

  assign last = (cnt == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst || ack) begin
      cnt <= '0;
      irq <= 1'b0;
    end else if (!irq) begin
      if (last) begin
        irq <= 1'b1;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int unsigned PERIOD = 1_000_000
) (
  input logic clk,
  input logic rst,
  input logic ack,
  input logic irq
);
  localparam int unsigned SW = $clog2(PERIOD + 1);

  logic [SW-1:0] since;

  always_ff @(posedge clk) begin
    if (rst || ack)              since <= '0;
    else if (since != SW'(PERIOD)) since <= since + 1'b1;
  end

  // R2 R5 R6 R7
  irq_timing_chk: assert property (@(posedge clk) disable iff (rst)
    (irq == (since == SW'(PERIOD))));

  // R3
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !ack) |=> irq);

  // R4 R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> !irq);

  // R1
  reset_low_chk: assert property (@(posedge clk)
    rst |=> !irq);

  // R7
  no_rise_on_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> !$past(ack));
endmodule

bind tick_timer tick_timer_chk #(.PERIOD(PERIOD)) u_chk (.*);

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
  localparam int unsigned PERIOD = 12;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ack = 1'b0;
  logic irq;

  int unsigned errors = 0;
  int unsigned checks = 0;
  int unsigned since = 0;
  bit finished = 1'b0;

  tick_timer #(.PERIOD(PERIOD)) dut (.clk(clk), .rst(rst), .ack(ack), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic expect_irq(int unsigned s);
    return (s >= PERIOD) ? 1'b1 : 1'b0;
  endfunction

  task automatic check(string tag, logic exp);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s: irq=%b expected=%b at t=%0t", tag, irq, exp, $time);
    end
  endtask

  task automatic step(logic r, logic a, string tag);
    logic prev_exp;
    string t;
    @(negedge clk);
    prev_exp = expect_irq(since);
    rst = r;
    ack = a;
    @(posedge clk);
    if (r || a) since = 0;
    else if (since < PERIOD) since++;
    #1;
    t = tag;
    if (t == "") begin
      if (r) t = "R1";
      else if (a) t = "R4";
      else if (prev_exp) t = "R3";
      else t = "R2";
    end
    check(t, expect_irq(since));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) step(1'b1, 1'b0, "R1");
    // R1: low through the first PERIOD-1 edges; R2: rise on edge PERIOD
    for (int i = 0; i < PERIOD - 1; i++) step(1'b0, 1'b0, "R1");
    step(1'b0, 1'b0, "R2");
    // R3: sticky while unacknowledged
    for (int i = 0; i < 25; i++) step(1'b0, 1'b0, "R3");
    // R4 then R5: fresh full interval from the ack
    step(1'b0, 1'b1, "R4");
    for (int i = 0; i < PERIOD - 1; i++) step(1'b0, 1'b0, "R5");
    step(1'b0, 1'b0, "R5");
    step(1'b0, 1'b1, "R4");
    // R6: mid-interval ack restarts and keeps irq low
    for (int i = 0; i < PERIOD / 2; i++) step(1'b0, 1'b0, "R6");
    step(1'b0, 1'b1, "R6");
    for (int i = 0; i < PERIOD; i++) step(1'b0, 1'b0, "R6");
    step(1'b0, 1'b1, "R4");
    // R7: ack on the expiry edge wins
    for (int i = 0; i < PERIOD - 1; i++) step(1'b0, 1'b0, "R7");
    step(1'b0, 1'b1, "R7");
    for (int i = 0; i < PERIOD; i++) step(1'b0, 1'b0, "R7");
    // R8: long held ack
    for (int i = 0; i < 3 * PERIOD; i++) step(1'b0, 1'b1, "R8");
    for (int i = 0; i < PERIOD + 2; i++) step(1'b0, 1'b0, "R8");
    // reset mid-run
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, "");
    step(1'b1, 1'b0, "R1");
    for (int i = 0; i < PERIOD + 3; i++) step(1'b0, 1'b0, "");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      r = $urandom_range(0, 99);
      if (r < 3) step(1'b1, 1'b0, "");
      else if (expect_irq(since) && r < 40) step(1'b0, 1'b1, "");
      else if (!expect_irq(since) && r < 8) step(1'b0, 1'b1, "R6");
      else step(1'b0, 1'b0, "");
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule